// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one vector memory operation into a sequence of per-element byte addresses. When the operation starts, the generator samples a scalar base address, a vector of per-element index values, a flag saying whether the base operand is a vector, an element-stride selector bit, a signed immediate, an operation width code and a vector length. It then walks an element counter from 0 up to the vector length minus one. For each element it presents the address, the access size in bytes and the element number on a valid/ready output.

The addressing style comes from the operand flags. A vector base operand selects indexed addressing. A scalar base with the stride bit clear selects unit stride. A scalar base with the stride bit set and a non-zero immediate selects a stride equal to the immediate. The element size always equals the operation size. A separate combinational path narrows a loaded 64-bit value to a destination element width by dropping its upper bits. This path never saturates.

Top module: `vec_ldst_agu`

## Requirements
- R1: When `base_is_vec` is 1 the operation uses indexed addressing whatever the value of `elem_stride`. `rsvd_enc` is then 0.
- R2: Unit stride (scalar base, `elem_stride`=0): element i's address is base + sext(imm) + i*size.
- R3: Element stride (scalar base, `elem_stride`=1, imm non-zero): element i's address is base + i*sext(imm).
- R4: Indexed: element i's address is idx_vec_in[64*i+63:64*i] + sext(imm).
- R5: A scalar base with `elem_stride`=1 and imm=0 uses unit-stride addressing, and `rsvd_enc` reads 1 from the cycle after start until the next start. `rsvd_enc` reads 0 for every other encoding.
- R6: Width code to `out_bytes`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. The unit-stride step equals that size.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_idx` hold their values. Each cycle with both high advances by one element.
- R8: `start` is accepted only while `idle` is 1. Elements come out in the order 0..n-1, where n is `vl_in` clamped to MAX_VL. `done` is high for exactly the one cycle after the last handshake, and `idle` returns the cycle after that.
- R9: A vector length of 0 produces no `out_valid`, and `done` is high in the cycle after start.
- R10: Address arithmetic wraps modulo 2^64.
- R11: `trunc_data` equals `ld_data` with every bit above the `dst_opw` element size forced to 0 (code 3 keeps all 64 bits). No saturation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken while idle) |
| base_in | input | 64 | Scalar base address |
| idx_vec_in | input | 512 | Per-element index values, element i in bits 64*i+63:64*i |
| base_is_vec | input | 1 | Base operand is a vector (selects indexed) |
| elem_stride | input | 1 | Element-stride selector bit |
| imm_in | input | 16 | Signed immediate offset |
| opw_in | input | 2 | Operation width code |
| vl_in | input | 4 | Vector length |
| idle | output | 1 | Ready to accept start |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Consumer accepts address |
| out_addr | output | 64 | Element byte address |
| out_bytes | output | 4 | Access size in bytes |
| out_idx | output | 4 | Element number |
| done | output | 1 | One-cycle end-of-operation pulse |
| rsvd_enc | output | 1 | Reserved encoding was used |
| ld_data | input | 64 | Loaded value to narrow |
| dst_opw | input | 2 | Destination element width code |
| trunc_data | output | 64 | Narrowed value |

## Verification
The start edge registers the operation. The first address and `rsvd_enc` are due at the next sample, so the bench reads them one cycle after it raises `start`. Each handshake is scored at the sample where valid and ready are both seen, and the following address is due one cycle later. A stall must repeat the same address at the next sample. `done` is checked exactly one sample after the final handshake, or one sample after start for a zero length. The truncation path is combinational and is checked in the same cycle its inputs change.

// File: rtl/vlsag_pkg.sv
package vlsag_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT  = 2'd0,
        MODE_ELEM  = 2'd1,
        MODE_INDEX = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        OPW_B = 2'd0,
        OPW_H = 2'd1,
        OPW_W = 2'd2,
        OPW_D = 2'd3
    } opw_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    // Access size in bytes for a width code.
    function automatic logic [3:0] opw_bytes(opw_e w);
        return 4'd1 << w;
    endfunction

endpackage

// File: rtl/vlsag_mode_dec.sv
module vlsag_mode_dec
    import vlsag_pkg::*;
(
    input  logic  base_is_vec,
    input  logic  elem_stride,
    input  logic  imm_zero,
    output mode_e mode,
    output logic  rsvd
);
    always_comb begin
        rsvd = 1'b0;
        if (base_is_vec) begin
            mode = MODE_INDEX;
        end else if (!elem_stride) begin
            mode = MODE_UNIT;
        end else if (!imm_zero) begin
            mode = MODE_ELEM;
        end else begin
            mode = MODE_UNIT;
            rsvd = 1'b1;
        end
    end
endmodule

// File: rtl/vlsag_addr_calc.sv
module vlsag_addr_calc
    import vlsag_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MAX_VL = 8,
    parameter int VL_W   = 4
) (
    input  mode_e                      mode,
    input  opw_e                       opw,
    input  logic [ADDR_W-1:0]          base,
    input  logic [ADDR_W-1:0]          imm,
    input  logic [VL_W-1:0]            idx,
    input  logic [MAX_VL*ADDR_W-1:0]   idx_vec,
    output logic [ADDR_W-1:0]          addr
);
    logic [ADDR_W-1:0] sel_idx;
    logic [ADDR_W-1:0] idx_ext;

    assign idx_ext = ADDR_W'(idx);

    always_comb begin
        sel_idx = '0;
        for (int k = 0; k < MAX_VL; k++) begin
            if (idx == VL_W'(k)) sel_idx = idx_vec[k*ADDR_W +: ADDR_W];
        end
    end

    always_comb begin
        unique case (mode)
            MODE_ELEM:  addr = base + (idx_ext * imm);
            MODE_INDEX: addr = sel_idx + imm;
            default:    addr = base + imm + (idx_ext << opw);
        endcase
    end
endmodule

// File: rtl/vlsag_trunc.sv
module vlsag_trunc
    import vlsag_pkg::*;
(
    input  logic [63:0] data_i,
    input  logic [1:0]  width,
    output logic [63:0] data_o
);
    always_comb begin
        unique case (opw_e'(width))
            OPW_B:   data_o = {56'd0, data_i[7:0]};
            OPW_H:   data_o = {48'd0, data_i[15:0]};
            OPW_W:   data_o = {32'd0, data_i[31:0]};
            default: data_o = data_i;
        endcase
    end

    // R11: nothing survives above the destination size
    always_comb begin
        a_r11_upper_zero: assert (width == 2'd3 ||
            (data_o >> (6'd8 << width)) == 64'd0);
    end
endmodule

// File: rtl/vec_ldst_agu.sv
module vec_ldst_agu
    import vlsag_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MAX_VL = 8,
    parameter int IMM_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         base_in,
    input  logic [MAX_VL*ADDR_W-1:0]  idx_vec_in,
    input  logic                      base_is_vec,
    input  logic                      elem_stride,
    input  logic [IMM_W-1:0]          imm_in,
    input  logic [1:0]                opw_in,
    input  logic [VL_W-1:0]           vl_in,
    output logic                      idle,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [ADDR_W-1:0]         out_addr,
    output logic [3:0]                out_bytes,
    output logic [VL_W-1:0]           out_idx,
    output logic                      done,
    output logic                      rsvd_enc,
    input  logic [63:0]               ld_data,
    input  logic [1:0]                dst_opw,
    output logic [63:0]               trunc_data
);
    state_e                    state_q;
    mode_e                     mode_d, mode_q;
    logic                      rsvd_d;
    opw_e                      opw_q;
    logic [ADDR_W-1:0]         base_q, imm_q;
    logic [MAX_VL*ADDR_W-1:0]  idxv_q;
    logic [VL_W-1:0]           vl_q, idx_q, vl_eff;
    logic [ADDR_W-1:0]         imm_ext;

    assign imm_ext = {{(ADDR_W-IMM_W){imm_in[IMM_W-1]}}, imm_in};
    assign vl_eff  = (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;

    vlsag_mode_dec u_dec (
        .base_is_vec (base_is_vec),
        .elem_stride (elem_stride),
        .imm_zero    (imm_in == '0),
        .mode        (mode_d),
        .rsvd        (rsvd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_UNIT;
            opw_q    <= OPW_B;
            base_q   <= '0;
            imm_q    <= '0;
            idxv_q   <= '0;
            vl_q     <= '0;
            idx_q    <= '0;
            rsvd_enc <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    mode_q   <= mode_d;
                    opw_q    <= opw_e'(opw_in);
                    base_q   <= base_in;
                    imm_q    <= imm_ext;
                    idxv_q   <= idx_vec_in;
                    vl_q     <= vl_eff;
                    idx_q    <= '0;
                    rsvd_enc <= rsvd_d;
                    state_q  <= (vl_eff == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (out_ready) begin
                    if (idx_q == vl_q - VL_W'(1)) state_q <= ST_FIN;
                    else                          idx_q   <= idx_q + VL_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    vlsag_addr_calc #(
        .ADDR_W (ADDR_W),
        .MAX_VL (MAX_VL),
        .VL_W   (VL_W)
    ) u_calc (
        .mode    (mode_q),
        .opw     (opw_q),
        .base    (base_q),
        .imm     (imm_q),
        .idx     (idx_q),
        .idx_vec (idxv_q),
        .addr    (out_addr)
    );

    vlsag_trunc u_trunc (
        .data_i (ld_data),
        .width  (dst_opw),
        .data_o (trunc_data)
    );

    assign idle      = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_RUN);
    assign done      = (state_q == ST_FIN);
    assign out_idx   = idx_q;
    assign out_bytes = opw_bytes(opw_q);

    // R7: a stalled element is held unchanged
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_idx));

    // R9: zero length goes straight to done
    a_r9_zero_len_done: assert property (@(posedge clk) disable iff (rst)
        idle && start && vl_in == '0 |=> done && !out_valid);

    // R8: element number stays inside the accepted length
    a_r8_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_idx < vl_q);

    // R8: done never overlaps an offered element and lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid ##1 !done);
endmodule

// File: tb/vec_ldst_agu_tb.sv
`timescale 1ns/1ps
module vec_ldst_agu_tb;
    typedef struct packed {
        logic [63:0] addr;
        logic [3:0]  bytes;
        logic [3:0]  idx;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [63:0]  base_in = '0;
    logic [511:0] idx_vec_in = '0;
    logic         base_is_vec = 1'b0;
    logic         elem_stride = 1'b0;
    logic [15:0]  imm_in = '0;
    logic [1:0]   opw_in = '0;
    logic [3:0]   vl_in = '0;
    logic         idle, out_valid, done, rsvd_enc;
    logic         out_ready = 1'b1;
    logic [63:0]  out_addr, trunc_data;
    logic [3:0]   out_bytes, out_idx;
    logic [63:0]  ld_data = '0;
    logic [1:0]   dst_opw = '0;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit   rand_ready = 1'b0;
    bit   zero_len_op = 1'b0;
    bit   prev_last = 1'b0;
    bit   hold_pending = 1'b0;
    logic [63:0] held_addr;
    logic [3:0]  held_idx;

    always #4 clk = ~clk;

    vec_ldst_agu u_dut (
        .clk(clk), .rst(rst), .start(start), .base_in(base_in),
        .idx_vec_in(idx_vec_in), .base_is_vec(base_is_vec),
        .elem_stride(elem_stride), .imm_in(imm_in), .opw_in(opw_in),
        .vl_in(vl_in), .idle(idle), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_bytes(out_bytes),
        .out_idx(out_idx), .done(done), .rsvd_enc(rsvd_enc),
        .ld_data(ld_data), .dst_opw(dst_opw), .trunc_data(trunc_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ready changes just after a rising edge, never at the sampling edge
    initial forever begin
        @(posedge clk);
        #1 out_ready <= rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        bit   last_now;
        exp_t e;
        last_now = 1'b0;
        if (!rst) begin
            if (done)
                chk(prev_last || zero_len_op, "R8 done timing", 64'(done), 64'(prev_last));
            if (hold_pending) begin
                chk(out_valid && out_addr == held_addr && out_idx == held_idx,
                    "R7 hold", out_addr, held_addr);
                hold_pending = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8/R9 unexpected element", out_addr, 64'd0);
                end else begin
                    e = q.pop_front();
                    chk(out_addr == e.addr, "R2/R3/R4/R10 addr", out_addr, e.addr);
                    chk(out_bytes == e.bytes, "R6 bytes", 64'(out_bytes), 64'(e.bytes));
                    chk(out_idx == e.idx, "R8 order", 64'(out_idx), 64'(e.idx));
                    last_now = (q.size() == 0);
                end
            end else if (out_valid) begin
                hold_pending = 1'b1;
                held_addr = out_addr;
                held_idx = out_idx;
            end
        end
        prev_last = last_now;
    end

    task automatic run_op(input logic [63:0] base, input bit isvec, input bit es,
                          input logic [15:0] imm, input logic [1:0] opw,
                          input logic [3:0] vl, input string req);
        logic [63:0] sx;
        int n, guard;
        bit rsv;
        exp_t e;
        sx  = {{48{imm[15]}}, imm};
        n   = (vl > 8) ? 8 : int'(vl);
        rsv = es && !isvec && imm == 16'd0;
        @(negedge clk);
        chk(idle, {req, " idle before start"}, 64'(idle), 64'd1);
        for (int i = 0; i < n; i++) begin
            e.bytes = 4'd1 << opw;
            e.idx   = 4'(i);
            if (isvec)           e.addr = idx_vec_in[i*64 +: 64] + sx;
            else if (es && !rsv) e.addr = base + 64'(i) * sx;
            else                 e.addr = base + sx + 64'(i) * 64'(e.bytes);
            q.push_back(e);
        end
        zero_len_op = (n == 0);
        base_in = base; base_is_vec = isvec; elem_stride = es;
        imm_in = imm; opw_in = opw; vl_in = vl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rsvd_enc == rsv, "R5/R1 rsvd_enc", 64'(rsvd_enc), 64'(rsv));
        if (n == 0) begin
            chk(done && !out_valid, "R9 zero length", 64'(done), 64'd1);
        end else begin
            // a start while busy must be ignored (R8)
            start = 1'b1; vl_in = 4'd0;
        end
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            start = 1'b0;
            guard++;
        end
        start = 1'b0;
        chk(guard < 200, {req, " done seen"}, 64'(guard), 64'd0);
        chk(q.size() == 0, {req, " all elements"}, 64'(q.size()), 64'd0);
        q.delete();
        @(negedge clk);
        chk(idle && !done, "R8 idle after done", 64'(idle), 64'd1);
        zero_len_op = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(idle && !out_valid && !done && !rsvd_enc, "R8 reset state", 64'(idle), 64'd1);

        // R2 R6: unit stride, word size
        run_op(64'h1000, 0, 0, 16'd8, 2'd2, 4'd4, "R2");
        // R3: element stride, negative immediate, stalls
        rand_ready = 1'b1;
        run_op(64'h2000, 0, 1, 16'hFFF0, 2'd1, 4'd3, "R3");
        // R1 R4: indexed; stride bit ignored, no reserved flag
        for (int i = 0; i < 8; i++) idx_vec_in[i*64 +: 64] = 64'h4000_0000 + 64'(i * 'h111);
        run_op(64'hDEAD, 1, 1, 16'd0, 2'd3, 4'd5, "R1/R4");
        run_op(64'hDEAD, 1, 0, 16'h0020, 2'd0, 4'd8, "R4");
        // R5: reserved encoding falls back to unit stride
        run_op(64'h3000, 0, 1, 16'd0, 2'd1, 4'd4, "R5");
        // R9: zero length
        run_op(64'h5000, 0, 0, 16'd4, 2'd2, 4'd0, "R9");
        // R10: wrap around the top of the address space
        run_op(64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 16'd0, 2'd1, 4'd4, "R10");
        run_op(64'h10, 0, 1, 16'hFFF8, 2'd0, 4'd4, "R10 elem");
        // R8 R6: length above MAX_VL is clamped, byte and doubleword sizes
        run_op(64'h7000, 0, 0, 16'd1, 2'd0, 4'd10, "R8 clamp");
        rand_ready = 1'b0;
        run_op(64'h8000, 0, 0, 16'd0, 2'd3, 4'd3, "R6");

        // R11: truncation, no saturation
        ld_data = 64'h8899_AABB_CCDD_EEFF;
        for (int w = 0; w < 4; w++) begin
            logic [63:0] ex;
            dst_opw = 2'(w);
            ex = (w == 3) ? ld_data : (ld_data & ((64'd1 << (8 << w)) - 64'd1));
            #1;
            chk(trunc_data == ex, "R11 truncate", trunc_data, ex);
        end
        ld_data = 64'hFFFF_FFFF_0001_8000;
        dst_opw = 2'd1;
        #1;
        chk(trunc_data == 64'h8000, "R11 no saturation", trunc_data, 64'h8000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule